// File: doc/BRIEF.md
# Prioritized Edge/Level Interrupt Controller

This block gathers 32 active-high request lines and turns them into two processor interrupt outputs. One is the normal interrupt and the other is the fast interrupt. Each line has a configuration word with three settings: whether the line is edge or level sensitive, which output it is routed to, and a 5-bit priority. A per-line mask gates every line out of arbitration.

A simple word-wide register bus lets software work the block. Software can read and AND-clear the pending vector and write the mask. It can read the latched winner code of each output, configure lines, raise a line by software and re-arm an output once it has serviced it. Each output fires at most once per re-arm. When it fires, it latches the number of the best qualifying line. Reading that code acknowledges the line if the line is edge-type.

Bus reads are combinational: `bus_rdata` is valid in the same cycle as a read strobe, and any side effect of the read takes place at the next clock edge. Only `bus_addr[7:2]` is decoded.

Top module: `prio_intc`

## Requirements
- R1: After reset the pending vector reads 0, the mask (0x04) reads 0xFFFFFFFF, every configuration word reads 0, and both outputs are low.
- R2: The configuration word of line n sits at 0x1C+4n. Bit 0 routes the line to the fast output (1) or the normal output (0). Bit 1 selects level (1) or edge (0) sensitivity. Bits [6:2] hold the priority. A read returns this packing with all other bits zero.
- R3: An edge-type line becomes pending (bit n of 0x00) at the clock edge after its input is seen low in one cycle and high in the next. It stays pending after the input drops.
- R4: A level-type line becomes pending at every clock edge where its input is high. It clears at the edge where its input is first seen low. A pending write cannot clear it while the input is high.
- R5: A write to 0x00 replaces the pending vector with its AND with the written data. Protected level lines (R4) are the exception.
- R6: For each output, only lines that are pending, unmasked (mask bit 0) and routed to that output compete. The smallest priority value wins, and among equal priorities the higher line number wins.
- R7: While an output is armed and a competitor exists, the next clock edge drives the output high, latches the winner number and disarms the output. The output and the latched number then hold until a re-arm.
- R8: Writing 0x18 with bit 0 (normal) or bit 1 (fast) set re-arms that output at that clock edge. It does so against the current competitors: the output goes low if none exists, or stays high with a freshly latched winner if one does.
- R9: Reading 0x10 (normal) or 0x14 (fast) returns the latched winner number. If that line is edge-type, its pending bit clears at that clock edge.
- R10: A write to 0x9C acts as a request on the lowest set bit of the data only. An edge-type line is set only if its input is low at that time, and a level-type line is always set.
- R11: The mask register at 0x04 is written whole. Reads of 0x18 and 0x9C, and of any unmapped address, return 0. Writes to unmapped addresses and to the code registers change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Bus access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address; bits [7:2] decoded |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| lines_in | input | 32 | Active-high interrupt request lines |
| irq_o | output | 1 | Normal interrupt output |
| fiq_o | output | 1 | Fast interrupt output |

## Verification
The assertions assume `bus_en` and `bus_wr` are always driven to known values. They also assume that a re-arm is only ever signalled through a bus write to the control word, so that an output can drop only in a re-arm cycle. The bench keeps within this by driving every bus signal from a single task at the falling edge, with word-aligned addresses only. The random stimulus toggles request lines sparsely, so edge and level lines, pending writes, acknowledges and re-arms all overlap often.

// File: rtl/prio_intc.sv
module prio_intc #(
  parameter int NLINES = 32,
  parameter int PRIO_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NLINES-1:0] lines_in,
  output logic              irq_o,
  output logic              fiq_o
);
  localparam int LW       = $clog2(NLINES);
  localparam int W_PEND   = 0;
  localparam int W_MASK   = 1;
  localparam int W_CODE0  = 4;
  localparam int W_CODE1  = 5;
  localparam int W_CTRL   = 6;
  localparam int W_CFG    = 7;
  localparam int W_SWTRIG = W_CFG + NLINES;

  logic [NLINES-1:0] pend, mask, lvl, fiqsel, in_q;
  logic [PRIO_W-1:0] prio [NLINES];
  logic [LW-1:0]     code_q [2];
  logic [1:0]        out_q;

  wire [5:0] widx = bus_addr[7:2];
  wire rd_s = bus_en & ~bus_wr;
  wire wr_s = bus_en & bus_wr;
  wire cfg_hit = (int'(widx) >= W_CFG) && (int'(widx) < W_SWTRIG);
  wire [5:0] cfg_off = widx - 6'(W_CFG);
  wire [LW-1:0] cfg_line = cfg_off[LW-1:0];

  generate
    for (genvar c = 0; c < 2; c++) begin : g_cls
      logic [NLINES-1:0] cand;
      logic [PRIO_W:0]   best;
      logic              found;
      logic [LW-1:0]     win;
      logic              armed;
      wire rearm = wr_s && (int'(widx) == W_CTRL) && bus_wdata[c];

      assign cand = pend & ~mask & ((c == 1) ? fiqsel : ~fiqsel);

      always_comb begin
        best  = {1'b1, {PRIO_W{1'b0}}};
        found = 1'b0;
        win   = '0;
        for (int i = 0; i < NLINES; i++) begin
          if (cand[i] && ({1'b0, prio[i]} <= best)) begin
            best  = {1'b0, prio[i]};
            win   = LW'(i);
            found = 1'b1;
          end
        end
      end

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          armed     <= 1'b1;
          out_q[c]  <= 1'b0;
          code_q[c] <= '0;
        end else if ((armed || rearm) && found) begin
          armed     <= 1'b0;
          out_q[c]  <= 1'b1;
          code_q[c] <= win;
        end else if (rearm) begin
          armed     <= 1'b1;
          out_q[c]  <= 1'b0;
        end
      end
    end
  endgenerate

  assign irq_o = out_q[0];
  assign fiq_o = out_q[1];

  logic [NLINES-1:0] sw_pick, sw_set, ack_clr, wr_clr, clr_v, set_v;

  always_comb begin
    sw_pick = '0;
    for (int i = NLINES - 1; i >= 0; i--) begin
      if (bus_wdata[i]) begin
        sw_pick    = '0;
        sw_pick[i] = 1'b1;
      end
    end
  end

  assign sw_set = (wr_s && int'(widx) == W_SWTRIG) ? (sw_pick & (lvl | ~lines_in)) : '0;
  assign wr_clr = (wr_s && int'(widx) == W_PEND) ?
                  ~(bus_wdata[NLINES-1:0] | (lines_in & lvl)) : '0;

  always_comb begin
    ack_clr = '0;
    if (rd_s && int'(widx) == W_CODE0) ack_clr[code_q[0]] = ~lvl[code_q[0]];
    if (rd_s && int'(widx) == W_CODE1) ack_clr[code_q[1]] = ~lvl[code_q[1]];
  end

  assign clr_v = (lvl & in_q & ~lines_in) | wr_clr | ack_clr;
  assign set_v = (~lvl & lines_in & ~in_q) | (lvl & lines_in) | sw_set;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend   <= '0;
      mask   <= '1;
      lvl    <= '0;
      fiqsel <= '0;
      in_q   <= '0;
      for (int i = 0; i < NLINES; i++) prio[i] <= '0;
    end else begin
      in_q <= lines_in;
      pend <= (pend & ~clr_v) | set_v;
      if (wr_s && int'(widx) == W_MASK) mask <= bus_wdata[NLINES-1:0];
      if (wr_s && cfg_hit) begin
        prio[cfg_line]   <= bus_wdata[2 +: PRIO_W];
        lvl[cfg_line]    <= bus_wdata[1];
        fiqsel[cfg_line] <= bus_wdata[0];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_s) begin
      case (int'(widx))
        W_PEND:  bus_rdata = 32'(pend);
        W_MASK:  bus_rdata = 32'(mask);
        W_CODE0: bus_rdata = 32'(code_q[0]);
        W_CODE1: bus_rdata = 32'(code_q[1]);
        default: if (cfg_hit)
                   bus_rdata = 32'({prio[cfg_line], lvl[cfg_line], fiqsel[cfg_line]});
      endcase
    end
  end
endmodule

module prio_intc_sva #(
  parameter int NLINES = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              bus_wr,
  input logic [7:0]        bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [NLINES-1:0] lines_in,
  input logic              irq_o,
  input logic              fiq_o,
  input logic [NLINES-1:0] pend,
  input logic [NLINES-1:0] mask,
  input logic [NLINES-1:0] lvl,
  input logic [NLINES-1:0] fiqsel
);
  wire ctrl_wr = bus_en && bus_wr && (bus_addr[7:2] == 6'd6);

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !(ctrl_wr && bus_wdata[0])) |=> irq_o); // R7
  AST_FIQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fiq_o && !(ctrl_wr && bus_wdata[1])) |=> fiq_o); // R7
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(|(pend & ~mask & ~fiqsel))); // R6
  AST_FIQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fiq_o) |-> $past(|(pend & ~mask & fiqsel))); // R6
  AST_LEVEL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & $past(lvl & lines_in)) == $past(lvl & lines_in))); // R4
endmodule

bind prio_intc prio_intc_sva #(.NLINES(NLINES)) u_sva (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .lines_in(lines_in),
  .irq_o(irq_o), .fiq_o(fiq_o), .pend(pend), .mask(mask),
  .lvl(lvl), .fiqsel(fiqsel)
);

// File: tb/test_prio_intc.sv
module test_prio_intc;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, lines_in = '0;
  logic        irq_o, fiq_o;
  int n_chk = 0, n_err = 0;

  prio_intc i_prio_intc (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .lines_in(lines_in), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] m_pend, m_mask, m_lvl, m_fiq, m_inq;
  logic [4:0]  m_prio [32];
  logic        m_arm [2];
  logic        m_out [2];
  logic [4:0]  m_code [2];

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic void m_reset();
    m_pend = '0; m_mask = '1; m_lvl = '0; m_fiq = '0; m_inq = '0;
    for (int i = 0; i < 32; i++) m_prio[i] = '0;
    for (int c = 0; c < 2; c++) begin m_arm[c] = 1; m_out[c] = 0; m_code[c] = '0; end
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] a);
    int w = int'(a[7:2]);
    if (w == 0) return m_pend;
    if (w == 1) return m_mask;
    if (w == 4) return 32'(m_code[0]);
    if (w == 5) return 32'(m_code[1]);
    if (w >= 7 && w <= 38) return {25'd0, m_prio[w-7], m_lvl[w-7], m_fiq[w-7]};
    return '0;
  endfunction

  function automatic void m_step(input logic [31:0] ln, input logic en, input logic wr,
                                 input logic [7:0] a, input logic [31:0] wd);
    int w = int'(a[7:2]);
    bit rd = en && !wr, wt = en && wr;
    bit f [2];
    logic [4:0] win [2];
    logic [31:0] clr, set;
    for (int c = 0; c < 2; c++) begin
      int best = 99;
      f[c] = 0; win[c] = '0;
      for (int i = 0; i < 32; i++)
        if (m_pend[i] && !m_mask[i] && (m_fiq[i] == c[0]) && int'(m_prio[i]) <= best) begin
          best = int'(m_prio[i]); win[c] = 5'(i); f[c] = 1;
        end
    end
    clr = m_lvl & m_inq & ~ln;
    if (wt && w == 0) clr |= ~(wd | (ln & m_lvl));
    if (rd && (w == 4 || w == 5)) begin
      logic [4:0] k = m_code[w-4];
      if (!m_lvl[k]) clr[k] = 1'b1;
    end
    set = (~m_lvl & ln & ~m_inq) | (m_lvl & ln);
    if (wt && w == 39)
      for (int i = 0; i < 32; i++)
        if (wd[i]) begin
          if (m_lvl[i] || !ln[i]) set[i] = 1'b1;
          break;
        end
    for (int c = 0; c < 2; c++) begin
      bit re = wt && w == 6 && wd[c];
      if ((m_arm[c] || re) && f[c]) begin m_arm[c] = 0; m_out[c] = 1; m_code[c] = win[c]; end
      else if (re) begin m_arm[c] = 1; m_out[c] = 0; end
    end
    m_pend = (m_pend & ~clr) | set;
    if (wt && w == 1) m_mask = wd;
    if (wt && w >= 7 && w <= 38) begin
      m_prio[w-7] = wd[6:2]; m_lvl[w-7] = wd[1]; m_fiq[w-7] = wd[0];
    end
    m_inq = ln;
  endfunction

  task automatic op(input logic [31:0] ln, input logic en, input logic wr, input logic [7:0] a,
                    input logic [31:0] wd, input string req, output logic [31:0] rd);
    @(negedge clk);
    lines_in = ln; bus_en = en; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    #1;
    rd = bus_rdata;
    if (en && !wr) chk(req, "rdata", bus_rdata, m_read(a));
    m_step(ln, en, wr, a, wd);
    @(posedge clk); #1;
    chk(req, "irq_o", 32'(irq_o), 32'(m_out[0]));
    chk(req, "fiq_o", 32'(fiq_o), 32'(m_out[1]));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] r, ln;
    void'($urandom(32'd4242));
    m_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    op(0, 1, 0, 8'h00, 0, "R1", r); chk("R1", "pend", r, 32'h0);
    op(0, 1, 0, 8'h04, 0, "R1", r); chk("R1", "mask", r, 32'hFFFF_FFFF);
    op(0, 1, 0, 8'h2C, 0, "R1", r); chk("R1", "cfg", r, 32'h0);
    // R2 config packing: line 3 level prio 7
    op(0, 1, 1, 8'h28, 32'hFFFF_FF1E, "R2", r);
    op(0, 1, 0, 8'h28, 0, "R2", r); chk("R2", "cfg3", r, 32'h1E);
    // R11 mask write
    op(0, 1, 1, 8'h04, 32'h0, "R11", r);
    // R3 edge pulse on line 4
    op(32'h10, 0, 0, 0, 0, "R3", r);
    op(32'h0, 0, 0, 0, 0, "R3", r);
    op(32'h0, 1, 0, 8'h00, 0, "R3", r); chk("R3", "pend", r, 32'h10);
    chk("R7", "irq fired", 32'(irq_o), 1);
    // R9 code read acks edge line
    op(0, 1, 0, 8'h10, 0, "R9", r); chk("R9", "code", r, 4);
    op(0, 1, 0, 8'h00, 0, "R9", r); chk("R9", "pend after ack", r, 0);
    // R4 level line 3
    op(32'h8, 0, 0, 0, 0, "R4", r);
    op(32'h8, 1, 1, 8'h00, 0, "R4", r);
    op(32'h8, 1, 0, 8'h00, 0, "R4", r); chk("R4", "held", r, 32'h8);
    op(32'h0, 0, 0, 0, 0, "R4", r);
    op(32'h0, 1, 0, 8'h00, 0, "R4", r); chk("R4", "dropped", r, 0);
    // R8 re-arm with nothing pending
    op(0, 1, 1, 8'h18, 1, "R8", r); chk("R8", "irq low", 32'(irq_o), 0);
    // R6 tie: lines 10 and 20 prio 2 edge
    op(0, 1, 1, 8'h44, 32'h8, "R6", r);
    op(0, 1, 1, 8'h6C, 32'h8, "R6", r);
    op(32'h0010_0400, 0, 0, 0, 0, "R6", r);
    op(0, 0, 0, 0, 0, "R6", r);
    op(0, 1, 0, 8'h10, 0, "R6", r); chk("R6", "tie winner", r, 20);
    op(0, 1, 1, 8'h18, 1, "R8", r); chk("R8", "re-fire", 32'(irq_o), 1);
    op(0, 1, 0, 8'h10, 0, "R8", r); chk("R8", "new code", r, 10);
    // R10 software trigger, fast route on line 12
    op(0, 1, 1, 8'h4C, 32'h1, "R10", r);
    op(0, 1, 1, 8'h9C, 32'h0000_3000, "R10", r);
    op(0, 0, 0, 0, 0, "R10", r); chk("R10", "fiq", 32'(fiq_o), 1);
    op(0, 1, 0, 8'h14, 0, "R10", r); chk("R10", "fiq code", r, 12);
    // R5 AND write
    op(0, 1, 1, 8'h9C, 32'h2, "R5", r);
    op(0, 1, 1, 8'h9C, 32'h4, "R5", r);
    op(0, 1, 1, 8'h00, 32'hFFFF_FFFD, "R5", r);
    op(0, 1, 0, 8'h00, 0, "R5", r); chk("R5", "pend", r, 32'h4);
    // R11 unmapped and read-only
    op(0, 1, 1, 8'hA0, 32'hFFFF_FFFF, "R11", r);
    op(0, 1, 0, 8'hA0, 0, "R11", r); chk("R11", "unmapped", r, 0);
    op(0, 1, 0, 8'h18, 0, "R11", r); chk("R11", "ctrl read", r, 0);
    op(0, 1, 1, 8'h10, 32'h1F, "R11", r);
    op(0, 1, 0, 8'h00, 0, "R11", r); chk("R11", "pend intact", r, 32'h4);

    ln = '0;
    for (int n = 0; n < 6000; n++) begin
      int k = int'($urandom_range(0, 11));
      ln ^= $urandom & $urandom & $urandom & $urandom;
      case (k)
        0: op(ln, 1, 0, 8'h00, 0, "R3", r);
        1: op(ln, 1, 0, 8'h10, 0, "R9", r);
        2: op(ln, 1, 0, 8'h14, 0, "R9", r);
        3: op(ln, 1, 1, 8'h18, 32'($urandom_range(0, 3)), "R8", r);
        4: op(ln, 1, 1, 8'h04, $urandom | $urandom, "R11", r);
        5: op(ln, 1, 1, 8'(8'h1C + 4 * $urandom_range(0, 31)), $urandom & 32'h7F, "R2", r);
        6: op(ln, 1, 1, 8'h00, $urandom | $urandom, "R5", r);
        7: op(ln, 1, 1, 8'h9C, $urandom & $urandom, "R10", r);
        8: op(ln, 1, 0, 8'(8'h1C + 4 * $urandom_range(0, 31)), 0, "R2", r);
        default: op(ln, 0, 0, 0, 0, "R6", r);
      endcase
    end

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule